// File: doc/BRIEF.md
# Ingress Forwarding Decision Unit

This block takes the parsed header fields of one packet per cycle and returns one resolved forwarding action a cycle later. The header fields are the destination and source MAC, VLAN, VRF, destination IPv4 address, TTL and a flow hash. The unit compares the destination MAC with the configured router MAC. On a match the packet is routed. Otherwise it is bridged.

On the bridged path, two lookups run in the VLAN's MAC table. The source MAC lookup raises a learn or station-move event. The destination MAC lookup either selects the egress port or causes a flood. Each ingress port has a token budget that limits floods.

On the routed path, the destination address is matched within the VRF against a small prioritized route table. A hit on an ordinary route selects one member of a next-hop group using the flow hash, and that member supplies the egress processor, the egress port and a rewrite pointer. A hit on a directly attached subnet, or a TTL that has expired, sends the packet to the control plane. A shared token budget limits these punts. Software fills the tables through a simple write port.

Top module: `ingFwdDecide`

## Requirements
- R1: `resValid` rises exactly one cycle after `pktValid` and is low otherwise. Reset clears `resValid`, `learnEvt` and `moveEvt`, invalidates every MAC and route entry, and sets the router MAC to zero.
- R2: A packet whose destination MAC equals the router MAC takes the routed path (`resRouted`=1). Every other packet is bridged (`resRouted`=0).
- R3: On a bridged packet, a source MAC with no entry for the packet's VLAN raises `learnEvt`. A source MAC whose entry holds a port other than `pktInPort` raises `moveEvt`. A routed packet raises neither event, and neither does a bridged packet whose source entry holds the ingress port.
- R4: On a bridged packet whose destination MAC has an entry in its VLAN, the action is forward (code 0) and `resPort` is the port of that entry. When several entries match, the lowest index wins. Processor and rewrite outputs are 0 on this path.
- R5: A bridged destination miss gives flood (code 1) if the ingress port has a storm token, and drop (code 3) if it has none. Each port starts with STORM_BURST tokens, and each granted flood uses one. All tokens are refilled every REFILL_PERIOD cycles, and a flood granted in the refill cycle uses no token.
- R6: A routed lookup selects the lowest-index valid route whose VRF equals `pktVrf` and whose prefix matches the top `len` bits of `pktDip`. A length of 0 matches every address. If no route matches, the action is drop.
- R7: A routed hit on a route marked attached gives punt (code 2).
- R8: A routed packet with TTL 0 or 1 is punted, whatever the route lookup returns. A routed packet with TTL greater than 1 leaves with `resTtl` equal to TTL-1. A bridged packet leaves with its TTL unchanged.
- R9: A routed hit on a non-attached route forwards through next-hop index (base + hash mod count) mod 16. `resPort`, `resProc` and `resRewrite` come from that next-hop entry.
- R10: A punt is granted only when a punt token is left. Otherwise the action is drop. The unit starts with PUNT_BURST punt tokens, which are refilled on the same schedule as the storm tokens.
- R11: A configuration write (`cfgWe`) selects its table with `cfgSel` and its entry with `cfgIdx`. The encodings are:
  - `cfgSel`=0 writes a MAC entry: mac in [47:0], vlan in [59:48], port in [63:60].
  - `cfgSel`=1 writes a route: prefix in [31:0], len in [37:32], vrf in [41:38], attached in [42], base in [46:43], count-1 in [49:47].
  - `cfgSel`=2 writes a next hop: port in [3:0], processor in [7:4], rewrite in [23:8].
  - `cfgSel`=3 writes the router MAC from [47:0].
  - A MAC or route write marks that entry valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfgWe | input | 1 | Table write strobe |
| cfgSel | input | 2 | Table select |
| cfgIdx | input | 4 | Entry index |
| cfgData | input | 64 | Entry contents |
| pktValid | input | 1 | Header fields valid this cycle |
| pktInPort | input | 4 | Ingress port |
| pktDmac | input | 48 | Destination MAC |
| pktSmac | input | 48 | Source MAC |
| pktVlan | input | 12 | VLAN |
| pktVrf | input | 4 | VRF |
| pktDip | input | 32 | Destination IPv4 address |
| pktTtl | input | 8 | TTL |
| pktHash | input | 16 | Flow hash |
| resValid | output | 1 | Result valid |
| resAction | output | 2 | 0 forward, 1 flood, 2 punt, 3 drop |
| resRouted | output | 1 | Routed path taken |
| resPort | output | 4 | Egress port on forward, else 0 |
| resProc | output | 4 | Egress processor on routed forward, else 0 |
| resRewrite | output | 16 | Rewrite pointer on routed forward, else 0 |
| resTtl | output | 8 | Outgoing TTL |
| learnEvt | output | 1 | New source address seen |
| moveEvt | output | 1 | Known source address seen on another port |

## Verification
The assertions assume that `pktValid` stays low while `rst` is high. They also assume that no table is written in the same cycle as a packet that would read it. Without that second assumption, a lookup would see the table as it was before the write.

The stimulus respects both assumptions. It programs the tables while the packet stream is idle, and it releases reset before the first packet. After that, random and directed packets run back to back, and those include storm bursts from one port and bursts of punts that drain the token budgets across refill boundaries.

// File: rtl/fwdPkg.sv
package fwdPkg;
  localparam int PORT_W    = 4;
  localparam int PORTS     = 1 << PORT_W;
  localparam int NH_W      = 4;
  localparam int NH_N      = 1 << NH_W;
  localparam int VLAN_W    = 12;
  localparam int VRF_W     = 4;
  localparam int HASH_W    = 16;
  localparam int PROC_W    = 4;
  localparam int REWR_W    = 16;
  localparam int CFG_IDX_W = 4;

  typedef enum logic [1:0] {
    ACT_FWD   = 2'd0,
    ACT_FLOOD = 2'd1,
    ACT_PUNT  = 2'd2,
    ACT_DROP  = 2'd3
  } action_e;

  // datapath asks the control for a token
  typedef struct packed {
    logic              flood;
    logic              punt;
    logic [PORT_W-1:0] port;
  } tokReq_t;

  // control answers with grant strobes
  typedef struct packed {
    logic floodOk;
    logic puntOk;
  } tokGrant_t;
endpackage

// File: rtl/fwdCtrl.sv
module fwdCtrl
  import fwdPkg::*;
#(
  parameter int STORM_BURST   = 4,
  parameter int PUNT_BURST    = 2,
  parameter int REFILL_PERIOD = 256
) (
  input  logic      clk,
  input  logic      rst,
  input  tokReq_t   req,
  output tokGrant_t grant
);
  localparam int MAXB  = (STORM_BURST > PUNT_BURST) ? STORM_BURST : PUNT_BURST;
  localparam int TOK_W = $clog2(MAXB + 1);
  localparam int CNT_W = $clog2(REFILL_PERIOD);

  logic [TOK_W-1:0] stormTok [PORTS];
  logic [TOK_W-1:0] puntTok;
  logic [TOK_W:0]   puntsInWin;
  logic [CNT_W-1:0] refillCnt;
  logic             refill, floodTake, puntTake;

  assign refill        = refillCnt == CNT_W'(REFILL_PERIOD - 1);
  assign grant.floodOk = stormTok[req.port] != '0;
  assign grant.puntOk  = puntTok != '0;
  assign floodTake     = req.flood && grant.floodOk;
  assign puntTake      = req.punt && grant.puntOk;

  always_ff @(posedge clk) begin
    if (rst || refill) begin
      refillCnt  <= '0;
      puntTok    <= TOK_W'(PUNT_BURST);
      puntsInWin <= '0;
      for (int p = 0; p < PORTS; p++) stormTok[p] <= TOK_W'(STORM_BURST);
    end else begin
      refillCnt <= refillCnt + CNT_W'(1);
      if (floodTake) stormTok[req.port] <= stormTok[req.port] - TOK_W'(1);
      if (puntTake) begin
        puntTok    <= puntTok - TOK_W'(1);
        puntsInWin <= puntsInWin + (TOK_W+1)'(1);
      end
    end
  end

  for (genvar p = 0; p < PORTS; p++) begin : g_cap
    AST_STORM_CAP: assert property (@(posedge clk) disable iff (rst)
      stormTok[p] <= TOK_W'(STORM_BURST)); // R5
  end

  AST_PUNT_WINDOW: assert property (@(posedge clk) disable iff (rst)
    puntsInWin <= (TOK_W+1)'(PUNT_BURST)); // R10
endmodule

// File: rtl/fwdPath.sv
module fwdPath
  import fwdPkg::*;
#(
  parameter int MAC_N = 8,
  parameter int RT_N  = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cfgWe,
  input  logic [1:0]           cfgSel,
  input  logic [CFG_IDX_W-1:0] cfgIdx,
  input  logic [63:0]          cfgData,
  input  logic                 pktValid,
  input  logic [PORT_W-1:0]    pktInPort,
  input  logic [47:0]          pktDmac,
  input  logic [47:0]          pktSmac,
  input  logic [VLAN_W-1:0]    pktVlan,
  input  logic [VRF_W-1:0]     pktVrf,
  input  logic [31:0]          pktDip,
  input  logic [7:0]           pktTtl,
  input  logic [HASH_W-1:0]    pktHash,
  input  tokGrant_t            grant,
  output tokReq_t              req,
  output logic                 resValid,
  output action_e              resAction,
  output logic                 resRouted,
  output logic [PORT_W-1:0]    resPort,
  output logic [PROC_W-1:0]    resProc,
  output logic [REWR_W-1:0]    resRewrite,
  output logic [7:0]           resTtl,
  output logic                 learnEvt,
  output logic                 moveEvt
);
  // tables
  logic [47:0]       macAddr [MAC_N];
  logic [VLAN_W-1:0] macVlan [MAC_N];
  logic [PORT_W-1:0] macPort [MAC_N];
  logic [MAC_N-1:0]  macVld;
  logic [31:0]       rtPfx   [RT_N];
  logic [5:0]        rtLen   [RT_N];
  logic [VRF_W-1:0]  rtVrf   [RT_N];
  logic [NH_W-1:0]   rtBase  [RT_N];
  logic [2:0]        rtCntM1 [RT_N];
  logic [RT_N-1:0]   rtAtt, rtVld;
  logic [PORT_W-1:0] nhPort  [NH_N];
  logic [PROC_W-1:0] nhProc  [NH_N];
  logic [REWR_W-1:0] nhRw    [NH_N];
  logic [47:0]       rtrMac;

  always_ff @(posedge clk) begin
    if (rst) begin
      macVld <= '0;
      rtVld  <= '0;
      rtrMac <= '0;
    end else if (cfgWe) begin
      unique case (cfgSel)
        2'd0: for (int i = 0; i < MAC_N; i++)
          if (cfgIdx == CFG_IDX_W'(i)) begin
            macAddr[i] <= cfgData[47:0];
            macVlan[i] <= cfgData[59:48];
            macPort[i] <= cfgData[63:60];
            macVld[i]  <= 1'b1;
          end
        2'd1: for (int i = 0; i < RT_N; i++)
          if (cfgIdx == CFG_IDX_W'(i)) begin
            rtPfx[i]   <= cfgData[31:0];
            rtLen[i]   <= cfgData[37:32];
            rtVrf[i]   <= cfgData[41:38];
            rtAtt[i]   <= cfgData[42];
            rtBase[i]  <= cfgData[46:43];
            rtCntM1[i] <= cfgData[49:47];
            rtVld[i]   <= 1'b1;
          end
        2'd2: for (int i = 0; i < NH_N; i++)
          if (cfgIdx == CFG_IDX_W'(i)) begin
            nhPort[i] <= cfgData[3:0];
            nhProc[i] <= cfgData[7:4];
            nhRw[i]   <= cfgData[23:8];
          end
        default: rtrMac <= cfgData[47:0];
      endcase
    end
  end

  function automatic logic [31:0] lenMask(input logic [5:0] len);
    return (len >= 6'd32) ? 32'hFFFF_FFFF : ~(32'hFFFF_FFFF >> len);
  endfunction

  // lookups: descending scan so the lowest index is kept
  logic              sHit, dHit, rHit, rAtt;
  logic [PORT_W-1:0] sPort, dPort;
  logic [NH_W-1:0]   rBase, nhIdx;
  logic [2:0]        rCntM1;
  logic [3:0]        grpSize;
  logic [HASH_W-1:0] memOff;

  always_comb begin
    sHit = 1'b0; sPort = '0; dHit = 1'b0; dPort = '0;
    for (int i = MAC_N - 1; i >= 0; i--) begin
      if (macVld[i] && macVlan[i] == pktVlan && macAddr[i] == pktSmac) begin
        sHit = 1'b1; sPort = macPort[i];
      end
      if (macVld[i] && macVlan[i] == pktVlan && macAddr[i] == pktDmac) begin
        dHit = 1'b1; dPort = macPort[i];
      end
    end
    rHit = 1'b0; rAtt = 1'b0; rBase = '0; rCntM1 = '0;
    for (int i = RT_N - 1; i >= 0; i--) begin
      if (rtVld[i] && rtVrf[i] == pktVrf &&
          ((pktDip ^ rtPfx[i]) & lenMask(rtLen[i])) == 32'd0) begin
        rHit = 1'b1; rAtt = rtAtt[i]; rBase = rtBase[i]; rCntM1 = rtCntM1[i];
      end
    end
    grpSize = {1'b0, rCntM1} + 4'd1;
    memOff  = pktHash % HASH_W'(grpSize);
    nhIdx   = NH_W'(rBase + memOff);
  end

  // classification
  logic    routed, wantPunt, wantFlood;
  action_e act;

  assign routed    = pktDmac == rtrMac;
  assign wantPunt  = routed && (pktTtl <= 8'd1 || (rHit && rAtt));
  assign wantFlood = !routed && !dHit;
  assign req.flood = pktValid && wantFlood;
  assign req.punt  = pktValid && wantPunt;
  assign req.port  = pktInPort;

  always_comb begin
    if (routed) begin
      if (wantPunt)  act = grant.puntOk ? ACT_PUNT : ACT_DROP;
      else if (rHit) act = ACT_FWD;
      else           act = ACT_DROP;
    end else begin
      if (dHit)      act = ACT_FWD;
      else           act = grant.floodOk ? ACT_FLOOD : ACT_DROP;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      resValid <= 1'b0;
      learnEvt <= 1'b0;
      moveEvt  <= 1'b0;
    end else begin
      resValid <= pktValid;
      learnEvt <= pktValid && !routed && !sHit;
      moveEvt  <= pktValid && !routed && sHit && sPort != pktInPort;
    end
    resAction  <= act;
    resRouted  <= routed;
    resTtl     <= (routed && pktTtl > 8'd1) ? pktTtl - 8'd1 : pktTtl;
    resPort    <= (act != ACT_FWD) ? '0 : (routed ? nhPort[nhIdx] : dPort);
    resProc    <= (act == ACT_FWD && routed) ? nhProc[nhIdx] : '0;
    resRewrite <= (act == ACT_FWD && routed) ? nhRw[nhIdx] : '0;
  end

  AST_RESULT_LATENCY: assert property (@(posedge clk) disable iff (rst)
    resValid == $past(pktValid)); // R1
  AST_TTL_DEC: assert property (@(posedge clk) disable iff (rst)
    (resValid && resRouted && $past(pktTtl) > 8'd1) |-> resTtl == $past(pktTtl) - 8'd1); // R8
  AST_EVT_BRIDGED: assert property (@(posedge clk) disable iff (rst)
    (learnEvt || moveEvt) |-> (resValid && !resRouted)); // R3
endmodule

// File: rtl/ingFwdDecide.sv
module ingFwdDecide
  import fwdPkg::*;
#(
  parameter int MAC_N         = 8,
  parameter int RT_N          = 8,
  parameter int STORM_BURST   = 4,
  parameter int PUNT_BURST    = 2,
  parameter int REFILL_PERIOD = 256
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cfgWe,
  input  logic [1:0]           cfgSel,
  input  logic [CFG_IDX_W-1:0] cfgIdx,
  input  logic [63:0]          cfgData,
  input  logic                 pktValid,
  input  logic [PORT_W-1:0]    pktInPort,
  input  logic [47:0]          pktDmac,
  input  logic [47:0]          pktSmac,
  input  logic [VLAN_W-1:0]    pktVlan,
  input  logic [VRF_W-1:0]     pktVrf,
  input  logic [31:0]          pktDip,
  input  logic [7:0]           pktTtl,
  input  logic [HASH_W-1:0]    pktHash,
  output logic                 resValid,
  output logic [1:0]           resAction,
  output logic                 resRouted,
  output logic [PORT_W-1:0]    resPort,
  output logic [PROC_W-1:0]    resProc,
  output logic [REWR_W-1:0]    resRewrite,
  output logic [7:0]           resTtl,
  output logic                 learnEvt,
  output logic                 moveEvt
);
  tokReq_t   req;
  tokGrant_t grant;
  action_e   act;

  assign resAction = act;

  fwdCtrl #(
    .STORM_BURST(STORM_BURST), .PUNT_BURST(PUNT_BURST), .REFILL_PERIOD(REFILL_PERIOD)
  ) u_ctrl (
    .clk(clk), .rst(rst), .req(req), .grant(grant)
  );

  fwdPath #(.MAC_N(MAC_N), .RT_N(RT_N)) u_path (
    .clk(clk), .rst(rst),
    .cfgWe(cfgWe), .cfgSel(cfgSel), .cfgIdx(cfgIdx), .cfgData(cfgData),
    .pktValid(pktValid), .pktInPort(pktInPort), .pktDmac(pktDmac), .pktSmac(pktSmac),
    .pktVlan(pktVlan), .pktVrf(pktVrf), .pktDip(pktDip), .pktTtl(pktTtl), .pktHash(pktHash),
    .grant(grant), .req(req),
    .resValid(resValid), .resAction(act), .resRouted(resRouted), .resPort(resPort),
    .resProc(resProc), .resRewrite(resRewrite), .resTtl(resTtl),
    .learnEvt(learnEvt), .moveEvt(moveEvt)
  );
endmodule

// File: tb/ingFwdDecide_test.sv
module ingFwdDecide_test;
  localparam int MN = 8, RN = 8, SB = 4, PB = 2, RP = 256;

  logic clk = 1'b0, rst = 1'b1;
  logic cfgWe = 1'b0; logic [1:0] cfgSel = '0; logic [3:0] cfgIdx = '0; logic [63:0] cfgData = '0;
  logic pktValid = 1'b0; logic [3:0] pktInPort = '0; logic [47:0] pktDmac = '0, pktSmac = '0;
  logic [11:0] pktVlan = '0; logic [3:0] pktVrf = '0; logic [31:0] pktDip = '0;
  logic [7:0] pktTtl = '0; logic [15:0] pktHash = '0;
  logic resValid, resRouted, learnEvt, moveEvt;
  logic [1:0] resAction; logic [3:0] resPort, resProc; logic [15:0] resRewrite; logic [7:0] resTtl;

  always #5 clk = ~clk;

  ingFwdDecide #(.MAC_N(MN), .RT_N(RN), .STORM_BURST(SB), .PUNT_BURST(PB), .REFILL_PERIOD(RP)) uut (
    .clk(clk), .rst(rst), .cfgWe(cfgWe), .cfgSel(cfgSel), .cfgIdx(cfgIdx), .cfgData(cfgData),
    .pktValid(pktValid), .pktInPort(pktInPort), .pktDmac(pktDmac), .pktSmac(pktSmac),
    .pktVlan(pktVlan), .pktVrf(pktVrf), .pktDip(pktDip), .pktTtl(pktTtl), .pktHash(pktHash),
    .resValid(resValid), .resAction(resAction), .resRouted(resRouted), .resPort(resPort),
    .resProc(resProc), .resRewrite(resRewrite), .resTtl(resTtl),
    .learnEvt(learnEvt), .moveEvt(moveEvt));

  int nChecks = 0, nFail = 0;

  task automatic chk(input string tag, input logic [63:0] a, input logic [63:0] e);
    nChecks++;
    if (a !== e) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, a, e, $time);
    end
  endtask

  // reference tables
  logic [47:0] mMac [MN]; logic [11:0] mVlan [MN]; logic [3:0] mPort [MN]; bit mMacV [MN];
  logic [31:0] mPfx [RN]; int mLen [RN]; logic [3:0] mVrf [RN]; bit mAtt [RN]; int mBase [RN];
  int mCnt [RN]; bit mRtV [RN];
  logic [3:0] mNhPort [16]; logic [3:0] mNhProc [16]; logic [15:0] mNhRw [16];
  logic [47:0] mRtr = '0;
  int tCnt, tPunt; int tStorm [16];

  initial begin
    for (int i = 0; i < MN; i++) mMacV[i] = 0;
    for (int i = 0; i < RN; i++) mRtV[i] = 0;
  end

  function automatic logic [31:0] bmask(input int len);
    if (len == 0) return 32'd0;
    if (len >= 32) return 32'hFFFF_FFFF;
    return 32'hFFFF_FFFF << (32 - len);
  endfunction

  // expected values
  logic expV = 0, expLearn = 0, expMove = 0, expRouted; logic [1:0] expAct;
  logic [3:0] expPort, expProc; logic [15:0] expRw; logic [7:0] expTtl;
  string expTag, portTag;

  always @(posedge clk) begin
    if (rst) begin
      tCnt = 0; tPunt = PB;
      for (int p = 0; p < 16; p++) tStorm[p] = SB;
      expV = 0; expLearn = 0; expMove = 0;
    end else begin
      bit tookF, tookP, sHit, dHit, rHit;
      int sk, dk, rk, idx;
      tookF = 0; tookP = 0; sHit = 0; dHit = 0; rHit = 0; sk = 0; dk = 0; rk = 0;
      expV = pktValid; expLearn = 0; expMove = 0;
      expRouted = (pktDmac == mRtr);
      expPort = 0; expProc = 0; expRw = 0; expTtl = pktTtl; portTag = "R4 port";
      for (int i = 0; i < MN; i++) begin
        if (!sHit && mMacV[i] && mVlan[i] == pktVlan && mMac[i] == pktSmac) begin sHit = 1; sk = i; end
        if (!dHit && mMacV[i] && mVlan[i] == pktVlan && mMac[i] == pktDmac) begin dHit = 1; dk = i; end
      end
      for (int i = 0; i < RN; i++)
        if (!rHit && mRtV[i] && mVrf[i] == pktVrf && ((pktDip ^ mPfx[i]) & bmask(mLen[i])) == 0) begin
          rHit = 1; rk = i;
        end
      if (expRouted) begin
        if (pktTtl > 1) expTtl = pktTtl - 8'd1;
        if (pktTtl <= 1 || (rHit && mAtt[rk])) begin
          expTag = (pktTtl <= 1) ? "R8 ttl punt" : "R7 attached punt";
          if (tPunt > 0) begin expAct = 2'd2; tookP = pktValid; end
          else begin expAct = 2'd3; expTag = "R10 punt limit"; end
        end else if (rHit) begin
          idx = (mBase[rk] + int'(pktHash) % mCnt[rk]) % 16;
          expAct = 2'd0; expTag = "R6 route hit";
          expPort = mNhPort[idx]; expProc = mNhProc[idx]; expRw = mNhRw[idx];
          portTag = "R9 R11 next hop";
        end else begin
          expAct = 2'd3; expTag = "R6 route miss";
        end
      end else begin
        expLearn = pktValid && !sHit;
        expMove = pktValid && sHit && mPort[sk] != pktInPort;
        if (dHit) begin expAct = 2'd0; expPort = mPort[dk]; expTag = "R4 bridge hit"; end
        else if (tStorm[pktInPort] > 0) begin expAct = 2'd1; tookF = pktValid; expTag = "R5 flood"; end
        else begin expAct = 2'd3; expTag = "R5 storm drop"; end
      end
      if (tCnt == RP - 1) begin
        tCnt = 0; tPunt = PB;
        for (int p = 0; p < 16; p++) tStorm[p] = SB;
      end else begin
        tCnt++;
        if (tookF) tStorm[pktInPort]--;
        if (tookP) tPunt--;
      end
    end
  end

  logic armed = 0;
  always @(negedge clk) begin
    if (armed && !rst) begin
      chk("R1 valid", resValid, expV);
      chk("R3 learn", learnEvt, expLearn);
      chk("R3 move", moveEvt, expMove);
      if (expV) begin
        chk("R2 path", resRouted, expRouted);
        chk(expTag, resAction, expAct);
        chk(portTag, resPort, expPort);
        chk("R9 proc", resProc, expProc);
        chk("R9 rewrite", resRewrite, expRw);
        chk("R8 ttl out", resTtl, expTtl);
      end
    end
  end

  task automatic cfgWr(input logic [1:0] sel, input int idx, input logic [63:0] d);
    @(negedge clk);
    cfgWe = 1; cfgSel = sel; cfgIdx = 4'(idx); cfgData = d;
    @(negedge clk);
    cfgWe = 0;
  endtask

  task automatic wrMac(input int i, input logic [47:0] m, input logic [11:0] v, input logic [3:0] p);
    cfgWr(2'd0, i, {p, v, m});
    mMac[i] = m; mVlan[i] = v; mPort[i] = p; mMacV[i] = 1;
  endtask

  task automatic wrRoute(input int i, input logic [31:0] pf, input int len, input logic [3:0] vrf,
                         input bit att, input int base, input int cnt);
    cfgWr(2'd1, i, {14'd0, 3'(cnt - 1), 4'(base), att, vrf, 6'(len), pf});
    mPfx[i] = pf; mLen[i] = len; mVrf[i] = vrf; mAtt[i] = att; mBase[i] = base; mCnt[i] = cnt; mRtV[i] = 1;
  endtask

  task automatic wrNh(input int i, input logic [3:0] p, input logic [3:0] pr, input logic [15:0] rw);
    cfgWr(2'd2, i, {40'd0, rw, pr, p});
    mNhPort[i] = p; mNhProc[i] = pr; mNhRw[i] = rw;
  endtask

  task automatic pkt(input logic [3:0] ip, input logic [47:0] dm, input logic [47:0] sm,
                     input logic [11:0] vl, input logic [3:0] vr, input logic [31:0] dip,
                     input logic [7:0] ttl, input logic [15:0] h);
    pktValid = 1; pktInPort = ip; pktDmac = dm; pktSmac = sm; pktVlan = vl;
    pktVrf = vr; pktDip = dip; pktTtl = ttl; pktHash = h;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    pktValid = 0;
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  endtask

  localparam logic [47:0] RTR = 48'h00AA_BB00_0001;
  logic [47:0] known [6];

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset valid", resValid, 1'b0);
    chk("R1 reset learn", learnEvt, 1'b0);
    chk("R1 reset move", moveEvt, 1'b0);
    rst = 0; armed = 1;
    // tables empty after reset: bridged packet learns and floods (R1)
    pkt(4'd3, 48'h1111, 48'h2222, 12'd1, 4'd1, 32'd0, 8'd64, 16'd0);
    idle(2);
    cfgWr(2'd3, 0, {16'd0, RTR}); mRtr = RTR;
    for (int i = 0; i < 6; i++) begin
      known[i] = {16'h0200, $urandom()};
      wrMac(i, known[i], 12'(1 + i % 2), 4'($urandom_range(0, 15)));
    end
    wrMac(6, known[0], mVlan[0], mPort[0] + 4'd1); // shadowed duplicate, R4 lowest index
    for (int i = 0; i < 16; i++) wrNh(i, 4'(i + 1), 4'($urandom()), 16'($urandom()));
    wrRoute(0, 32'h0A00_0005, 32, 4'd1, 0, 0, 1);
    wrRoute(1, 32'h0A00_0000, 24, 4'd1, 1, 0, 1);
    wrRoute(2, 32'h1400_0000, 8, 4'd1, 0, 4, 3);
    wrRoute(3, 32'h1E00_0000, 16, 4'd1, 0, 2, 5);
    wrRoute(4, 32'h0000_0000, 0, 4'd2, 0, 12, 8);
    idle(1);
    // directed: storm burst from one port (R5)
    for (int k = 0; k < 7; k++) pkt(4'd5, 48'h0BAD_0000 + 48'(k), known[1], 12'd2, 4'd1, 32'd0, 8'd9, 16'd0);
    // directed: TTL expiry and attached punts exhaust the punt budget (R8, R10)
    pkt(4'd1, RTR, 48'h5, 12'd1, 4'd1, 32'h1400_0001, 8'd1, 16'd3);
    pkt(4'd1, RTR, 48'h5, 12'd1, 4'd1, 32'h1400_0001, 8'd0, 16'd3);
    pkt(4'd1, RTR, 48'h5, 12'd1, 4'd1, 32'h0A00_0009, 8'd7, 16'd3);
    pkt(4'd1, RTR, 48'h5, 12'd1, 4'd1, 32'h0A00_0005, 8'd2, 16'd7);   // host route wins (R6)
    pkt(4'd1, RTR, 48'h5, 12'd1, 4'd3, 32'h0A00_0005, 8'd2, 16'd7);   // wrong VRF miss (R6)
    pkt(4'd1, RTR, 48'h5, 12'd1, 4'd2, 32'hDEAD_BEEF, 8'd200, 16'hFFFF); // wrap (R9)
    // directed: move event (R3)
    pkt(mPort[2] + 4'd1, 48'h77, known[2], mVlan[2], 4'd1, 32'd0, 8'd5, 16'd0);
    pkt(mPort[2], known[3], known[2], mVlan[2], 4'd1, 32'd0, 8'd5, 16'd0);
    idle(1);
    // constrained random
    for (int n = 0; n < 1500; n++) begin
      logic [47:0] dm, sm; logic [31:0] dip; logic [7:0] ttl; int j;
      if ($urandom_range(0, 9) < 3) begin idle(1); continue; end
      j = $urandom_range(0, 5);
      case ($urandom_range(0, 2))
        0: dm = RTR;
        1: dm = known[j];
        default: dm = {16'h0300, $urandom()};
      endcase
      sm = ($urandom_range(0, 9) < 6) ? known[$urandom_range(0, 5)] : {16'h0400, $urandom()};
      case ($urandom_range(0, 4))
        0: dip = 32'h0A00_0005;
        1: dip = 32'h0A00_0000 | 32'($urandom_range(0, 255));
        2: dip = 32'h1400_0000 | ($urandom() & 32'h00FF_FFFF);
        3: dip = 32'h1E00_0000 | 32'($urandom_range(0, 65535));
        default: dip = $urandom();
      endcase
      ttl = ($urandom_range(0, 9) == 0) ? 8'($urandom_range(0, 1)) : 8'($urandom_range(2, 255));
      pkt(4'($urandom_range(0, 15)), dm, sm, 12'($urandom_range(1, 3)), 4'($urandom_range(1, 3)),
          dip, ttl, 16'($urandom()));
    end
    idle(3);
    summary();
  end

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end
endmodule